// File: doc/BRIEF.md
# Key-Locked Differential Output Router

This block sits between a stereo sample path and a pair of differential output stages. Each side (left and right) has a positive and a negative output. A small register bank, reached through a write-only port (address, data, strobe), holds a two-bit routing mode and a flag that turns off a clock-loss detector. The mode register is write-protected. Software must first store a fixed key word in a separate key register. Until it does, any write to the mode register is dropped. Storing any other value in the key register protects the mode register again.

On every cycle where the sample strobe is high, the router takes the signed left and right samples and drives four registered outputs from them. The active mode decides which channel each output carries and whether that channel is inverted. Normal and swapped stereo give each side a true/complement pair. The two mono modes spread one channel over all four outputs, so two copies of the block can together form a dual differential stereo pair. Inversion is saturating two's-complement negation.

Top module: `diff_route_ctrl`

## Requirements
- R1: After synchronous reset the mode register is protected, the mode field is 00 (stereo), `clkdet_off` is 0, all four sample outputs are 0 and `out_valid` is 0.
- R2: While protected, a write to the mode register (address 4) changes neither the routing nor `clkdet_off`.
- R3: A write of 0x01E0 (bits 8..5 set) to the key register (address 2) lifts the protection. A later write to address 4 then takes effect in the following cycle.
- R4: A write of any value other than 0x01E0 to address 2 restores the protection.
- R5: Mode field 00 (mode register bits 5:4): lp = L, ln = -L, rp = R, rn = -R.
- R6: Mode field 10: lp = R, ln = -R, rp = L, rn = -L.
- R7: Mode field 01: lp = L, ln = -L, rp = -L, rn = L.
- R8: Mode field 11: lp = -R, ln = R, rp = R, rn = -R.
- R9: Bit 6 of the mode register drives `clkdet_off` from the cycle after the write.
- R10: Negation saturates: the most negative sample inverts to the most positive value, and every other value inverts exactly.
- R11: The outputs load only on a clock edge where `smp_valid` is high. `out_valid` is high for exactly the cycle that follows such an edge. At other times the outputs hold their values.
- R12: Writes to addresses other than 2 and 4 change neither the protection state, the mode nor `clkdet_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 24 | Signed left sample |
| smp_right | input | 24 | Signed right sample |
| out_lp | output | 24 | Left positive output |
| out_ln | output | 24 | Left negative output |
| out_rp | output | 24 | Right positive output |
| out_rn | output | 24 | Right negative output |
| out_valid | output | 1 | Outputs updated in the previous edge |
| clkdet_off | output | 1 | Clock-loss detector disable |

## Verification
The protection state cannot be read, so it can only be seen through the routing it permits. The hardest case is proving that a write was ignored. To do this, the stimulus tries a mode change and then pushes a sample with distinct left and right values. The observed mapping must still match the old mode. The relock case is reached by first unlocking and selecting mono right. A wrong key is then written, followed by an attempt to return to stereo, and the sample is checked against mono right. Saturation is reached by feeding the most negative value on one channel and the most positive value on the other.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    MODE_STEREO = 2'b00,
    MODE_MONO_L = 2'b01,
    MODE_SWAP   = 2'b10,
    MODE_MONO_R = 2'b11
  } route_mode_e;

  localparam int LANES  = 4;
  localparam int LANE_LP = 0;
  localparam int LANE_LN = 1;
  localparam int LANE_RP = 2;
  localparam int LANE_RN = 3;

  typedef struct packed {
    logic take_right;
    logic invert;
  } lane_cfg_t;

  function automatic lane_cfg_t lane_cfg(input route_mode_e m, input int lane);
    lane_cfg_t c;
    c = '0;
    unique case (m)
      MODE_STEREO: begin
        c.take_right = (lane == LANE_RP) || (lane == LANE_RN);
        c.invert     = (lane == LANE_LN) || (lane == LANE_RN);
      end
      MODE_SWAP: begin
        c.take_right = (lane == LANE_LP) || (lane == LANE_LN);
        c.invert     = (lane == LANE_LN) || (lane == LANE_RN);
      end
      MODE_MONO_L: begin
        c.take_right = 1'b0;
        c.invert     = (lane == LANE_LN) || (lane == LANE_RP);
      end
      MODE_MONO_R: begin
        c.take_right = 1'b1;
        c.invert     = (lane == LANE_LP) || (lane == LANE_RN);
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/drc_regbank.sv
module drc_regbank
  import drc_pkg::*;
#(
  parameter int                ADDR_W    = 3,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 3'd2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 3'd4,
  parameter logic [DATA_W-1:0] KEY_WORD  = 16'h01E0,
  parameter int                MODE_LSB  = 4,
  parameter int                CDD_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output route_mode_e       mode_q,
  output logic              cdd_q,
  output logic              open_q
);

  logic key_hit;
  logic mode_hit;

  assign key_hit  = wr_en && (wr_addr == KEY_ADDR);
  assign mode_hit = wr_en && (wr_addr == MODE_ADDR) && open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (key_hit) begin
      open_q <= (wr_data == KEY_WORD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STEREO;
      cdd_q  <= 1'b0;
    end else if (mode_hit) begin
      mode_q <= route_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
      cdd_q  <= wr_data[CDD_BIT];
    end
  end

endmodule

// File: rtl/drc_satneg.sv
module drc_satneg #(
  parameter int W = 24
) (
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (din == MOST_NEG) dout = MOST_POS;
    else                 dout = -din;
  end

endmodule

// File: rtl/drc_lane.sv
module drc_lane
  import drc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  lane_cfg_t           cfg,
  input  logic signed [W-1:0] left,
  input  logic signed [W-1:0] right,
  output logic signed [W-1:0] q
);

  logic signed [W-1:0] picked;
  logic signed [W-1:0] picked_neg;

  assign picked = cfg.take_right ? right : left;

  drc_satneg #(.W(W)) neg_i (
    .din  (picked),
    .dout (picked_neg)
  );

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= cfg.invert ? picked_neg : picked;
  end

endmodule

// File: rtl/diff_route_ctrl.sv
module diff_route_ctrl
  import drc_pkg::*;
#(
  parameter int                SAMPLE_W  = 24,
  parameter int                ADDR_W    = 3,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 3'd2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 3'd4,
  parameter logic [DATA_W-1:0] KEY_WORD  = 16'h01E0,
  parameter int                MODE_LSB  = 4,
  parameter int                CDD_BIT   = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_left,
  input  logic signed [SAMPLE_W-1:0] smp_right,
  output logic signed [SAMPLE_W-1:0] out_lp,
  output logic signed [SAMPLE_W-1:0] out_ln,
  output logic signed [SAMPLE_W-1:0] out_rp,
  output logic signed [SAMPLE_W-1:0] out_rn,
  output logic                       out_valid,
  output logic                       clkdet_off
);

  route_mode_e         mode_q;
  logic                cdd_q;
  logic                open_q;
  logic signed [SAMPLE_W-1:0] lane_q [LANES];

  drc_regbank #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_ADDR  (KEY_ADDR),
    .MODE_ADDR (MODE_ADDR),
    .KEY_WORD  (KEY_WORD),
    .MODE_LSB  (MODE_LSB),
    .CDD_BIT   (CDD_BIT)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .cdd_q   (cdd_q),
    .open_q  (open_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_cfg_t cfg;
    assign cfg = lane_cfg(mode_q, g);
    drc_lane #(.W(SAMPLE_W)) lane_i (
      .clk   (clk),
      .rst   (rst),
      .load  (smp_valid),
      .cfg   (cfg),
      .left  (smp_left),
      .right (smp_right),
      .q     (lane_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= smp_valid;
  end

  assign out_lp     = lane_q[LANE_LP];
  assign out_ln     = lane_q[LANE_LN];
  assign out_rp     = lane_q[LANE_RP];
  assign out_rn     = lane_q[LANE_RN];
  assign clkdet_off = cdd_q;

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
  parameter int                W         = 24,
  parameter int                ADDR_W    = 3,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 3'd2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 3'd4,
  parameter logic [DATA_W-1:0] KEY_WORD  = 16'h01E0
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                smp_valid,
  input logic signed [W-1:0] out_lp,
  input logic signed [W-1:0] out_ln,
  input logic signed [W-1:0] out_rp,
  input logic signed [W-1:0] out_rn,
  input logic                out_valid,
  input logic                clkdet_off,
  input logic [1:0]          mode,
  input logic                unlocked
);

  function automatic logic signed [W-1:0] inv(input logic signed [W-1:0] x);
    if (x == {1'b1, {(W-1){1'b0}}}) return {1'b0, {(W-1){1'b1}}};
    return -x;
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!unlocked && mode == 2'b00 && !clkdet_off && !out_valid)); // R1

  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == MODE_ADDR && !unlocked) |=> ($stable(mode) && $stable(clkdet_off))); // R2

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == KEY_ADDR && wr_data == KEY_WORD) |=> unlocked); // R3

  AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == KEY_ADDR && wr_data != KEY_WORD) |=> !unlocked); // R4

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_ln == inv(out_lp) || out_lp == inv(out_ln)) &&
                   (out_rn == inv(out_rp) || out_rp == inv(out_rn)))); // R10

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> (!out_valid && $stable(out_lp) && $stable(out_ln) &&
                    $stable(out_rp) && $stable(out_rn))); // R11

  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != KEY_ADDR && wr_addr != MODE_ADDR) |=>
      ($stable(unlocked) && $stable(mode) && $stable(clkdet_off))); // R12

endmodule

bind diff_route_ctrl drc_checker #(
  .W         (SAMPLE_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .KEY_ADDR  (KEY_ADDR),
  .MODE_ADDR (MODE_ADDR),
  .KEY_WORD  (KEY_WORD)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .smp_valid  (smp_valid),
  .out_lp     (out_lp),
  .out_ln     (out_ln),
  .out_rp     (out_rp),
  .out_rn     (out_rn),
  .out_valid  (out_valid),
  .clkdet_off (clkdet_off),
  .mode       (mode_q),
  .unlocked   (open_q)
);

// File: tb/diff_route_ctrl_tb_top.sv
module diff_route_ctrl_tb_top;

  localparam int W = 24;
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic              smp_valid = 1'b0;
  logic signed [W-1:0] smp_left = '0;
  logic signed [W-1:0] smp_right = '0;
  logic signed [W-1:0] out_lp, out_ln, out_rp, out_rn;
  logic              out_valid;
  logic              clkdet_off;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  diff_route_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .out_lp     (out_lp),
    .out_ln     (out_ln),
    .out_rp     (out_rp),
    .out_rn     (out_rn),
    .out_valid  (out_valid),
    .clkdet_off (clkdet_off)
  );

  function automatic logic signed [W-1:0] ng(input logic signed [W-1:0] x);
    if (x == SMIN) return SMAX;
    return -x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  // mode codes: 00 stereo, 10 swap, 01 mono left, 11 mono right
  task automatic push(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                      input logic [1:0] m, input string req);
    logic signed [W-1:0] e_lp, e_ln, e_rp, e_rn;
    case (m)
      2'b00:   begin e_lp = l;     e_ln = ng(l); e_rp = r;     e_rn = ng(r); end
      2'b10:   begin e_lp = r;     e_ln = ng(r); e_rp = l;     e_rn = ng(l); end
      2'b01:   begin e_lp = l;     e_ln = ng(l); e_rp = ng(l); e_rn = l;     end
      default: begin e_lp = ng(r); e_ln = r;     e_rp = r;     e_rn = ng(r); end
    endcase
    @(negedge clk);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
    check(out_valid == 1'b1, "R11", "out_valid after strobe", out_valid, 1);
    check(out_lp == e_lp, req, "out_lp", out_lp, e_lp);
    check(out_ln == e_ln, req, "out_ln", out_ln, e_ln);
    check(out_rp == e_rp, req, "out_rp", out_rp, e_rp);
    check(out_rn == e_rn, req, "out_rn", out_rn, e_rn);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    check(clkdet_off == 1'b0, "R1", "clkdet_off", clkdet_off, 0);
    check(out_lp == 0 && out_ln == 0 && out_rp == 0 && out_rn == 0, "R1",
          "outputs zero", out_lp, 0);
    push(24'sd1000, -24'sd2000, 2'b00, "R1");
  endtask

  task automatic t_locked;
    write_reg(3'd4, 16'h0070);
    check(clkdet_off == 1'b0, "R2", "clkdet_off while locked", clkdet_off, 0);
    push(24'sd123, 24'sd456, 2'b00, "R2");
  endtask

  task automatic t_unlock_and_modes;
    write_reg(3'd2, 16'h01E0);
    write_reg(3'd4, 16'h0020);
    push(24'sd77, -24'sd88, 2'b10, "R3");
    push(-24'sd5, 24'sd9, 2'b10, "R6");
    write_reg(3'd4, 16'h0000);
    push(24'sd3141, -24'sd2718, 2'b00, "R5");
    write_reg(3'd4, 16'h0010);
    push(24'sd4000, 24'sd17, 2'b01, "R7");
    write_reg(3'd4, 16'h0030);
    push(24'sd4000, -24'sd17, 2'b11, "R8");
  endtask

  task automatic t_cdd;
    write_reg(3'd4, 16'h0070);
    check(clkdet_off == 1'b1, "R9", "clkdet_off set", clkdet_off, 1);
    push(24'sd10, 24'sd20, 2'b11, "R9");
    write_reg(3'd4, 16'h0030);
    check(clkdet_off == 1'b0, "R9", "clkdet_off cleared", clkdet_off, 0);
  endtask

  task automatic t_other_addr;
    write_reg(3'd5, 16'h0000);
    write_reg(3'd0, 16'h0040);
    write_reg(3'd6, 16'h01E1);
    check(clkdet_off == 1'b0, "R12", "clkdet_off", clkdet_off, 0);
    push(24'sd31, 24'sd62, 2'b11, "R12");
    // still open: a mode write must work
    write_reg(3'd4, 16'h0010);
    push(24'sd31, 24'sd62, 2'b01, "R12");
    write_reg(3'd4, 16'h0030);
  endtask

  task automatic t_relock;
    write_reg(3'd2, 16'h01E1);
    write_reg(3'd4, 16'h0040);
    check(clkdet_off == 1'b0, "R4", "clkdet_off after relock", clkdet_off, 0);
    push(-24'sd600, 24'sd700, 2'b11, "R4");
  endtask

  task automatic t_saturate;
    write_reg(3'd2, 16'h01E0);
    write_reg(3'd4, 16'h0000);
    push(SMIN, SMAX, 2'b00, "R10");
    write_reg(3'd4, 16'h0030);
    push(SMAX, SMIN, 2'b11, "R10");
  endtask

  task automatic t_hold;
    logic signed [W-1:0] h_lp, h_ln, h_rp, h_rn;
    write_reg(3'd4, 16'h0000);
    push(24'sd11, 24'sd22, 2'b00, "R11");
    h_lp = out_lp; h_ln = out_ln; h_rp = out_rp; h_rn = out_rn;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      smp_left = 24'sd999 + i; smp_right = -24'sd999 - i;
    end
    check(out_valid == 1'b0, "R11", "out_valid idle", out_valid, 0);
    check(out_lp == h_lp && out_ln == h_ln && out_rp == h_rp && out_rn == h_rn,
          "R11", "outputs held", out_lp, h_lp);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_locked();
    t_unlock_and_modes();
    t_cdd();
    t_other_addr();
    t_relock();
    t_saturate();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule